// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic heart of a small fixed-point signal processor. Two 16-bit operand registers feed a signed multiplier. The upper 24 bits of the 32-bit product, optionally shifted right arithmetically by three, are captured in a read-only product register. A 24-bit accumulator takes the result of an ALU. The ALU can load the product, add it or subtract it, add or subtract an operand register aligned to the accumulator's upper word, or clear. Each operation records negative, overflow, zero and carry flags. An optional saturation mode clamps results that overflow.

Software-facing transfers are 16 bits wide. A 16-bit write to the accumulator lands in its upper word and clears the low byte. A 16-bit read of the accumulator or the product returns the upper word. The operand registers can also be read back, so they can serve as scratch storage while the multiplier is idle. Instruction decode and sequencing live outside this block, which sees only the write strobes, the ALU select and the mode bits.

Top module: `mac_datapath`

## Requirements
- R1: After reset the accumulator, the product register, both operand registers and all four flags are zero, and `prod_valid` is low.
- R2: `wr_x_en` / `wr_y_en` load `wr_data` into the X / Y operand register. Both can be read back unchanged through `rd_sel`, and neither write alters the accumulator.
- R3: `wr_a_en` loads `{wr_data, 8'h00}` into the accumulator. It takes priority over an ALU operation in the same cycle, and it leaves the flags unchanged.
- R4: `rd_data` returns accumulator bits 23:8 for `rd_sel`=0, product bits 23:8 for 1, X for 2 and Y for 3.
- R5: After X and/or Y is written at clock edge k, the product register takes bits 31:8 of the signed 16x16 product at edge k+1. `prod_valid` is high during the cycle after edge k+1, and is low again one cycle later unless further operand writes follow.
- R6: With `shift3_mode` set at the product-load edge, the captured 24-bit product is arithmetically shifted right by three.
- R7: `alu_op` codes: 0 and 7 do nothing. 1 sets A=P, 2 sets A=A+P, 3 sets A=A-P, 4 sets A=A+{X,8'h00}, 5 sets A=A-{X,8'h00}, 6 sets A=0. An operation takes effect at the edge where `alu_en` is high.
- R8: `flags` = {N, OV, Z, C} in bits 3..0. Every effective ALU operation (codes 1 to 6) updates them. N is bit 23 of the stored result, and Z is set when the stored result is zero.
- R9: C is the carry out of bit 23 for additions and the unsigned borrow (A below the operand) for subtractions. OV is signed 24-bit overflow. For load and clear, both C and OV are zero.
- R10: With `sat_mode` set, an overflowing result is stored as 24'h7FFFFF on positive overflow and 24'h800000 on negative overflow, with OV still set.
- R11: With `sat_mode` clear, an overflowing result wraps modulo 2^24.
- R12: An ALU operation in the same cycle as an operand write uses the product held before that write. With `alu_en` low, or with codes 0 and 7, the accumulator and flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_data | input | 16 | Transfer data for register writes |
| wr_x_en | input | 1 | Write X operand |
| wr_y_en | input | 1 | Write Y operand |
| wr_a_en | input | 1 | Write accumulator upper word, clear low byte |
| alu_en | input | 1 | Perform the selected ALU operation this cycle |
| alu_op | input | 3 | ALU operation code |
| shift3_mode | input | 1 | Arithmetic right shift of the product by three |
| sat_mode | input | 1 | Saturate the accumulator on overflow |
| rd_sel | input | 2 | Transfer read source: 0 A, 1 P, 2 X, 3 Y |
| rd_data | output | 16 | 16-bit transfer read value |
| acc_out | output | 24 | Full accumulator contents |
| flags | output | 4 | {N, OV, Z, C} |
| prod_valid | output | 1 | New product present in P this cycle |

## Verification
Two things can happen in one cycle: a write to X/Y that starts a new product, and an accumulate that reads P. The bench provokes this by first building a known product, then issuing an add-product and a new X write in the same cycle. It checks that the accumulator took the old product, and that P shows the new product two edges later. A second collision, an accumulator write together with a clear, is judged by the stored word and by flags that do not change.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    ALU_IDLE  = 3'd0,
    ALU_LDP   = 3'd1,
    ALU_ADDP  = 3'd2,
    ALU_SUBP  = 3'd3,
    ALU_ADDX  = 3'd4,
    ALU_SUBX  = 3'd5,
    ALU_CLR   = 3'd6,
    ALU_IDLE2 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic c;
  } alu_flags_t;

  localparam int unsigned RD_SEL_W = 2;

endpackage

// File: rtl/mac_operand_regs.sv
module mac_operand_regs #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_x_en,
  input  logic              wr_y_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic              load_pend_q
);

  logic [DATA_W-1:0] x_d, y_d;
  logic              load_pend_d;

  always_comb begin
    x_d         = x_q;
    y_d         = y_q;
    load_pend_d = wr_x_en | wr_y_en;
    if (wr_x_en) x_d = wr_data;
    if (wr_y_en) y_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q         <= '0;
      y_q         <= '0;
      load_pend_q <= 1'b0;
    end else begin
      x_q         <= x_d;
      y_q         <= y_d;
      load_pend_q <= load_pend_d;
    end
  end

  // R2
  x_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_x_en |=> (x_q == $past(wr_data)));

  // R2
  y_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_y_en |=> $stable(y_q));

endmodule

// File: rtl/mac_product_reg.sv
module mac_product_reg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACC_W   = 24,
  parameter int unsigned SHIFT_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              load_i,
  input  logic              shift_mode,
  output logic [ACC_W-1:0]  p_q,
  output logic              valid_q
);

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] full_prod;
  logic signed [ACC_W-1:0]  upper_prod;
  logic signed [ACC_W-1:0]  scaled_prod;
  logic [ACC_W-1:0]         p_d;
  logic                     valid_d;

  always_comb begin
    full_prod  = $signed(x_i) * $signed(y_i);
    upper_prod = full_prod[PROD_W-1 -: ACC_W];
  end

  generate
    if (SHIFT_N == 0) begin : g_noshift
      always_comb scaled_prod = upper_prod;
    end else begin : g_shift
      always_comb scaled_prod = shift_mode ? (upper_prod >>> SHIFT_N) : upper_prod;
    end
  endgenerate

  always_comb begin
    p_d     = load_i ? scaled_prod : p_q;
    valid_d = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      p_q     <= p_d;
      valid_q <= valid_d;
    end
  end

  // R5
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(p_q));

  // R5
  prod_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_q);

  // R6
  shift_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && shift_mode) |=>
      ((p_q[ACC_W-1 -: SHIFT_N+1] == '0) || (p_q[ACC_W-1 -: SHIFT_N+1] == '1)));

endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 24
) (
  input  logic [ACC_W-1:0]  a_i,
  input  logic [ACC_W-1:0]  p_i,
  input  logic [DATA_W-1:0] x_i,
  input  alu_op_e           op_i,
  input  logic              sat_mode,
  output logic [ACC_W-1:0]  res_o,
  output alu_flags_t        flags_o,
  output logic              active_o
);

  localparam int unsigned GUARD_W = ACC_W - DATA_W;
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] opnd_b;
  logic [ACC_W:0]   sum_ext;
  logic [ACC_W:0]   dif_ext;
  logic [ACC_W-1:0] raw;
  logic             ov_raw;
  logic             carry;
  logic             is_sub;
  logic             is_arith;

  always_comb begin
    is_sub   = (op_i == ALU_SUBP) || (op_i == ALU_SUBX);
    is_arith = (op_i == ALU_ADDP) || (op_i == ALU_SUBP) ||
               (op_i == ALU_ADDX) || (op_i == ALU_SUBX);
    active_o = (op_i != ALU_IDLE) && (op_i != ALU_IDLE2);

    if ((op_i == ALU_ADDX) || (op_i == ALU_SUBX))
      opnd_b = {x_i, {GUARD_W{1'b0}}};
    else
      opnd_b = p_i;

    sum_ext = {1'b0, a_i} + {1'b0, opnd_b};
    dif_ext = {1'b0, a_i} - {1'b0, opnd_b};

    raw    = '0;
    ov_raw = 1'b0;
    carry  = 1'b0;
    if (op_i == ALU_LDP) begin
      raw = p_i;
    end else if (is_arith && !is_sub) begin
      raw    = sum_ext[ACC_W-1:0];
      carry  = sum_ext[ACC_W];
      ov_raw = (a_i[ACC_W-1] == opnd_b[ACC_W-1]) && (raw[ACC_W-1] != a_i[ACC_W-1]);
    end else if (is_arith) begin
      raw    = dif_ext[ACC_W-1:0];
      carry  = dif_ext[ACC_W];
      ov_raw = (a_i[ACC_W-1] != opnd_b[ACC_W-1]) && (raw[ACC_W-1] != a_i[ACC_W-1]);
    end

    if (sat_mode && ov_raw)
      res_o = raw[ACC_W-1] ? MAX_POS : MIN_NEG;
    else
      res_o = raw;

    flags_o.n  = res_o[ACC_W-1];
    flags_o.ov = ov_raw;
    flags_o.z  = (res_o == '0);
    flags_o.c  = carry;
  end

  always_comb begin
    // R10
    if (sat_mode && ov_raw) begin
      sat_bound_chk: assert ((res_o == MAX_POS) || (res_o == MIN_NEG));
    end
    // R9
    if (!is_arith) begin
      no_arith_flags_chk: assert (!flags_o.c && !flags_o.ov);
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACC_W   = 24,
  parameter int unsigned SHIFT_N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_x_en,
  input  logic                wr_y_en,
  input  logic                wr_a_en,
  input  logic                alu_en,
  input  logic [2:0]          alu_op,
  input  logic                shift3_mode,
  input  logic                sat_mode,
  input  logic [RD_SEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ACC_W-1:0]    acc_out,
  output logic [3:0]          flags,
  output logic                prod_valid
);

  localparam int unsigned GUARD_W = ACC_W - DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DATA_W-1:0] x_q, y_q;
  logic              load_pend;
  logic [ACC_W-1:0]  p_q;
  logic [ACC_W-1:0]  alu_res;
  alu_flags_t        alu_flags;
  logic              alu_active;
  logic [ACC_W-1:0]  acc_q, acc_d;
  alu_flags_t        flags_q, flags_d;
  logic              acc_en, flags_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mac_operand_regs #(.DATA_W(DATA_W)) opnd_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_x_en     (wr_x_en),
    .wr_y_en     (wr_y_en),
    .wr_data     (wr_data),
    .x_q         (x_q),
    .y_q         (y_q),
    .load_pend_q (load_pend)
  );

  mac_product_reg #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_N(SHIFT_N)) prod_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .x_i        (x_q),
    .y_i        (y_q),
    .load_i     (load_pend),
    .shift_mode (shift3_mode),
    .p_q        (p_q),
    .valid_q    (prod_valid)
  );

  mac_alu #(.DATA_W(DATA_W), .ACC_W(ACC_W)) alu_i (
    .a_i      (acc_q),
    .p_i      (p_q),
    .x_i      (x_q),
    .op_i     (alu_op_e'(alu_op)),
    .sat_mode (sat_mode),
    .res_o    (alu_res),
    .flags_o  (alu_flags),
    .active_o (alu_active)
  );

  always_comb begin
    acc_en   = wr_a_en | (alu_en & alu_active);
    flags_en = ~wr_a_en & alu_en & alu_active;
    acc_d    = wr_a_en ? {wr_data, {GUARD_W{1'b0}}} : alu_res;
    flags_d  = alu_flags;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      if (acc_en)   acc_q   <= acc_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = acc_q[ACC_W-1 -: DATA_W];
      2'd1:    rd_data = p_q[ACC_W-1 -: DATA_W];
      2'd2:    rd_data = x_q;
      default: rd_data = y_q;
    endcase
  end

  assign acc_out = acc_q;
  assign flags   = flags_q;

  // R3
  acc_word_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_a_en |=> (acc_q == {$past(wr_data), {GUARD_W{1'b0}}}) && $stable(flags_q));

  // R12
  acc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_a_en && !(alu_en && alu_active)) |=> ($stable(acc_q) && $stable(flags_q)));

  // R8
  nz_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_a_en && alu_en && alu_active) |=>
      ((flags_q.z == (acc_q == '0)) && (flags_q.n == acc_q[ACC_W-1])));

  // R5
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_x_en || wr_y_en) |=> ##1 prod_valid);

endmodule

// File: tb/mac_datapath_tb.sv
`timescale 1ns/1ps
module mac_datapath_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] wr_data;
  logic        wr_x_en, wr_y_en, wr_a_en, alu_en;
  logic [2:0]  alu_op;
  logic        shift3_mode, sat_mode;
  logic [1:0]  rd_sel;
  logic [15:0] rd_data;
  logic [23:0] acc_out;
  logic [3:0]  flags;
  logic        prod_valid;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mac_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_x_en(wr_x_en),
    .wr_y_en(wr_y_en), .wr_a_en(wr_a_en), .alu_en(alu_en), .alu_op(alu_op),
    .shift3_mode(shift3_mode), .sat_mode(sat_mode), .rd_sel(rd_sel),
    .rd_data(rd_data), .acc_out(acc_out), .flags(flags), .prod_valid(prod_valid)
  );

  // stimulus vectors {x, y, a16, op, shift, sat}; expectations from the model below
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {16'h0100, 16'h0200, 16'h0010, 3'd2, 1'b0, 1'b0},
    {16'hFF00, 16'h0300, 16'h0000, 3'd2, 1'b0, 1'b0},
    {16'h1234, 16'h5678, 16'h0100, 3'd3, 1'b0, 1'b0},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 3'd2, 1'b0, 1'b0},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 3'd2, 1'b0, 1'b1},
    {16'h7FFF, 16'h7FFF, 16'h8000, 3'd3, 1'b0, 1'b1},
    {16'h8000, 16'h8000, 16'h0000, 3'd1, 1'b0, 1'b0},
    {16'h8000, 16'h8000, 16'h0000, 3'd1, 1'b1, 1'b0},
    {16'hF000, 16'h0123, 16'h0000, 3'd1, 1'b1, 1'b0},
    {16'h4000, 16'h0001, 16'h4000, 3'd5, 1'b0, 1'b0},
    {16'h0003, 16'h0005, 16'h1234, 3'd6, 1'b0, 1'b0},
    {16'h8000, 16'h7FFF, 16'h8000, 3'd4, 1'b0, 1'b1},
    {16'h0001, 16'h0001, 16'h0050, 3'd2, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mdl_prod(input logic [15:0] x, input logic [15:0] y, input logic sh);
    longint m, p;
    m = longint'($signed(x)) * longint'($signed(y));
    p = m >>> 8;
    if (sh) p = p >>> 3;
    return p[23:0];
  endfunction

  function automatic logic [27:0] mdl_alu(input logic [23:0] a, input logic [23:0] p,
                                           input logic [15:0] x, input logic [2:0] op,
                                           input logic sat);
    longint sa, sb, s, ua, ub;
    logic [23:0] b, res;
    logic n, ov, z, c;
    b  = (op == 3'd4 || op == 3'd5) ? {x, 8'h00} : p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'(a);
    ub = longint'(b);
    ov = 1'b0; c = 1'b0; res = a;
    case (op)
      3'd1: res = p;
      3'd6: res = 24'h0;
      3'd2, 3'd4: begin
        s = sa + sb;
        c = (ua + ub) > 64'hFFFFFF;
        ov = (s > 8388607) || (s < -8388608);
        res = s[23:0];
        if (ov && sat) res = (s > 0) ? 24'h7FFFFF : 24'h800000;
      end
      3'd3, 3'd5: begin
        s = sa - sb;
        c = ua < ub;
        ov = (s > 8388607) || (s < -8388608);
        res = s[23:0];
        if (ov && sat) res = (s > 0) ? 24'h7FFFFF : 24'h800000;
      end
      default: ;
    endcase
    n = res[23];
    z = (res == 24'h0);
    return {n, ov, z, c, res};
  endfunction

  task automatic idle_inputs();
    wr_x_en = 0; wr_y_en = 0; wr_a_en = 0; alu_en = 0; alu_op = 3'd0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0]  fl_before;
    logic [23:0] acc_before;
    rst_n = 0; wr_data = 0; idle_inputs(); shift3_mode = 0; sat_mode = 0; rd_sel = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();

    // R1 reset state
    chk("R1 acc", acc_out, 0);
    chk("R1 flags", flags, 0);
    chk("R1 valid", prod_valid, 0);
    rd_sel = 1; #1 chk("R1 P", rd_data, 0);
    rd_sel = 2; #1 chk("R1 X", rd_data, 0);
    rd_sel = 3; #1 chk("R1 Y", rd_data, 0);

    // R2 operand registers as scratch, R5 strobe timing
    wr_data = 16'hA5A5; wr_x_en = 1; step();
    wr_x_en = 0; wr_data = 16'h5A5A; wr_y_en = 1;
    chk("R5 valid not yet", prod_valid, 0);
    step(); idle_inputs();
    chk("R5 valid after X", prod_valid, 1);
    step();
    chk("R5 valid after Y", prod_valid, 1);
    step();
    chk("R5 valid drop", prod_valid, 0);
    rd_sel = 2; #1 chk("R2 X readback", rd_data, 16'hA5A5);
    rd_sel = 3; #1 chk("R2 Y readback", rd_data, 16'h5A5A);
    chk("R2 acc untouched", acc_out, 0);

    // R3/R4 accumulator word write and read
    wr_data = 16'hBEEF; wr_a_en = 1; step(); idle_inputs();
    chk("R3 acc word", acc_out, 24'hBEEF00);
    rd_sel = 0; #1 chk("R4 read A", rd_data, 16'hBEEF);
    chk("R3 flags kept", flags, 0);

    // vector table: R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [15:0] vx, vy, va;
      logic [2:0]  vop;
      logic        vsh, vsat;
      logic [23:0] ep;
      logic [27:0] ea;
      {vx, vy, va, vop, vsh, vsat} = VEC[i];
      shift3_mode = vsh; sat_mode = vsat;
      wr_a_en = 1; wr_data = va; step();
      wr_a_en = 0; wr_x_en = 1; wr_y_en = 1; wr_data = vx; step();
      wr_x_en = 0; wr_data = vy; wr_y_en = 1; step();
      idle_inputs(); step();
      ep = mdl_prod(vx, vy, vsh);
      chk("R5 strobe", prod_valid, 1);
      rd_sel = 1; #1 chk("R5 R6 P word", rd_data, ep[23:8]);
      ea = mdl_alu({va, 8'h00}, ep, vx, vop, vsat);
      alu_en = 1; alu_op = vop; step(); idle_inputs();
      chk("R7 R10 R11 acc", acc_out, ea[23:0]);
      chk("R8 R9 flags", flags, ea[27:24]);
    end
    shift3_mode = 0; sat_mode = 0;

    // R12 same-cycle operand write and accumulate
    wr_a_en = 1; wr_data = 16'h0000; wr_x_en = 1; wr_y_en = 1;
    step(); idle_inputs(); wr_data = 16'h0100; wr_x_en = 1; wr_y_en = 1;
    step(); idle_inputs(); step(); step();
    rd_sel = 1; #1 chk("R5 P setup", rd_data, 16'h0001);
    wr_data = 16'h0200; wr_x_en = 1; alu_en = 1; alu_op = 3'd2;
    step(); idle_inputs();
    chk("R12 old P used", acc_out, 24'h000100);
    step();
    rd_sel = 1; #1 chk("R12 new P", rd_data, 16'h0002);

    // R12 hold cases
    fl_before = flags; acc_before = acc_out;
    alu_en = 0; alu_op = 3'd2; step(); idle_inputs();
    chk("R12 alu_en low acc", acc_out, acc_before);
    alu_en = 1; alu_op = 3'd0; step(); idle_inputs();
    chk("R12 op0 acc", acc_out, acc_before);
    chk("R12 op0 flags", flags, fl_before);
    alu_en = 1; alu_op = 3'd7; step(); idle_inputs();
    chk("R12 op7 acc", acc_out, acc_before);

    // R3 priority of word write over ALU clear
    fl_before = flags;
    wr_a_en = 1; wr_data = 16'h1357; alu_en = 1; alu_op = 3'd6;
    step(); idle_inputs();
    chk("R3 priority acc", acc_out, 24'h135700);
    chk("R3 priority flags", flags, fl_before);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule